// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block keeps a pending flag and an in-service flag for every one of 256 interrupt vectors and decides which pending vector, if any, may be handed to the processor core. A vector number doubles as its priority, and only its upper nibble, the priority class, takes part in comparisons. The block keeps a task priority set by software and a nesting stack of in-service vectors. From these it forms a processor priority. A pending vector is offered to the core only when its class beats the class of that priority.

Sources raise a vector through the set port. The core takes the offered vector through the accept port, which moves the vector from pending to in-service and nests it. When the handler finishes, an end-of-interrupt strobe retires the most urgent in-service vector. The lowest 32 vectors are reserved and are never offered, even when they are requested. Every update is registered, and the offered vector and the processor priority are formed from registered state in the cycle after each operation.

Top module: `vpa_arbiter`

## Requirements
- R1: After reset no vector is pending or in service, the task priority is zero, the nesting stack is empty, `ppr_out` reads 0x00 and `pend_valid` is low.
- R2: Only the highest requested vector is considered. It is offered on `pend_vec` with `pend_valid` high when its class (bits 7:4) is strictly greater than the class of `ppr_out`. Otherwise nothing is offered, and no lower requested vector is tried.
- R3: Vectors 0x00 to 0x1F are never offered. A request for one of them neither raises `pend_valid` nor hides a higher request.
- R4: `ppr_out` equals the task priority when its class is greater than or equal to the class of the most recently nested in-service vector (0x00 when nothing is in service). Otherwise it equals that vector with bits 3:0 cleared.
- R5: An accept of vector V clears V's request, marks V in service and nests it. The effect is visible in the following cycle.
- R6: An end-of-interrupt retires the highest in-service vector in 0x20 to 0xFF and unnests it. With nothing in service it changes nothing.
- R7: A task priority write keeps bits 7:0 of the 32-bit `tpr_wdata` and discards the rest. The new `ppr_out` shows in the next cycle.
- R8: A set and an accept in the same cycle both take effect. If both name the same vector, that vector ends up both in service and still requested.
- R9: An end-of-interrupt and an accept in the same cycle first retire the highest in-service vector and then nest the accepted one.
- R10: `pend_vec` reads 0x00 whenever `pend_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Raise a request for `set_vec` |
| set_vec | input | 8 | Vector to request |
| acc_valid | input | 1 | Core accepts `acc_vec` |
| acc_vec | input | 8 | Vector taken by the core |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 32 | Task priority write data; only bits 7:0 are kept |
| pend_valid | output | 1 | A deliverable vector is offered |
| pend_vec | output | 8 | Offered vector, 0x00 when none |
| ppr_out | output | 8 | Current processor priority |

## Verification
The offer logic is driven with requests above, equal to and below the class of the processor priority, so that a strict comparison can be told apart from a greater-or-equal one. Reserved-range requests sit underneath real requests, and a vector at 0x1F is set against one at 0x20 to place the reserved boundary exactly. The processor priority is reached from both of its sources: a task priority that beats the nested class, one that ties it, and one that loses to it, with wide write data to show the upper bits are dropped. Coinciding set/accept and end-of-interrupt/accept pairs, an end-of-interrupt with an empty stack, and a reset taken from a busy state show that every update lands and that nothing is left behind.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
   localparam int PRIO_W = 8;
   localparam int CLS_W  = 4;
   typedef logic [PRIO_W-1:0] prio_t;
   typedef logic [CLS_W-1:0]  cls_t;

   function automatic cls_t prio_class(prio_t p);
      return p[PRIO_W-1 -: CLS_W];
   endfunction
endpackage

// File: rtl/vpa_hi_find.sv
// Finds the highest set bit at or above word FIRST_WORD.
module vpa_hi_find #(
   parameter int NUM_BITS   = 256,
   parameter int WORD_W     = 32,
   parameter int FIRST_WORD = 1,
   parameter bit TWO_LEVEL  = 1'b1
) (
   input  logic [NUM_BITS-1:0]         bits,
   output logic                        found,
   output logic [$clog2(NUM_BITS)-1:0] idx
);
   localparam int IDX_W   = $clog2(NUM_BITS);
   localparam int NUM_WRD = NUM_BITS / WORD_W;
   localparam int LO_BIT  = FIRST_WORD * WORD_W;

   initial begin : p_param_chk
      assert (NUM_BITS % WORD_W == 0) else $error("word width must divide bit count");
      assert (FIRST_WORD < NUM_WRD) else $error("search range is empty");
   end

   if (FIRST_WORD > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^bits[LO_BIT-1:0];
   end

   if (TWO_LEVEL) begin : g_two
      logic [NUM_WRD-1:0] wany;
      for (genvar w = 0; w < NUM_WRD; w++) begin : g_w
         if (w >= FIRST_WORD) begin : g_on
            assign wany[w] = |bits[w*WORD_W +: WORD_W];
         end else begin : g_off
            assign wany[w] = 1'b0;
         end
      end
      always_comb begin
         int sel_w;
         int sel_b;
         logic [WORD_W-1:0] word;
         sel_w = 0;
         sel_b = 0;
         found = 1'b0;
         for (int w = FIRST_WORD; w < NUM_WRD; w++) begin
            if (wany[w]) begin
               sel_w = w;
               found = 1'b1;
            end
         end
         word = bits[sel_w*WORD_W +: WORD_W];
         for (int b = 0; b < WORD_W; b++) begin
            if (word[b]) sel_b = b;
         end
         idx = found ? IDX_W'(sel_w * WORD_W + sel_b) : '0;
      end
   end else begin : g_flat
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = LO_BIT; i < NUM_BITS; i++) begin
            if (bits[i]) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/vpa_nest_stack.sv
// Stack of nested in-service vectors; an empty stack reads as vector zero.
module vpa_nest_stack
   import vpa_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  push,
   input  logic  pop,
   input  prio_t push_vec,
   output prio_t top_vec
);
   localparam int PTR_W = $clog2(DEPTH + 1);

   initial begin : p_param_chk
      assert (DEPTH >= 1) else $error("stack depth must be positive");
   end

   prio_t            stk [1:DEPTH];
   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 1; i <= DEPTH; i++) stk[i] <= '0;
      end else if (push && pop && ptr != '0) begin
         stk[ptr] <= push_vec;
      end else if (push) begin
         stk[PTR_W'(ptr + 1'b1)] <= push_vec;
         ptr <= ptr + 1'b1;
      end else if (pop && ptr != '0) begin
         ptr <= ptr - 1'b1;
      end
   end

   assign top_vec = (ptr == '0) ? '0 : stk[ptr];

   // R5: nesting never runs past the stack
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (int'(ptr) < DEPTH));

   // R9: retire-and-nest keeps the depth
   a_r9_swap_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && ptr != '0) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/vpa_prio_calc.sv
// Processor priority from the task priority and the top nested vector.
module vpa_prio_calc
   import vpa_pkg::*;
(
   input  prio_t tpr,
   input  prio_t top_vec,
   output prio_t ppr
);
   always_comb begin
      if (prio_class(tpr) >= prio_class(top_vec)) ppr = tpr;
      else ppr = {prio_class(top_vec), {(PRIO_W-CLS_W){1'b0}}};
   end
endmodule

// File: rtl/vpa_arbiter.sv
module vpa_arbiter
   import vpa_pkg::*;
#(
   parameter int NUM_VEC        = 256,
   parameter int WORD_W         = 32,
   parameter int RSVD_WORDS     = 1,
   parameter int STK_DEPTH      = 16,
   parameter int TPR_BUS_W      = 32,
   parameter bit TWO_LEVEL_FIND = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_valid,
   input  logic [7:0]           set_vec,
   input  logic                 acc_valid,
   input  logic [7:0]           acc_vec,
   input  logic                 eoi,
   input  logic                 tpr_we,
   input  logic [TPR_BUS_W-1:0] tpr_wdata,
   output logic                 pend_valid,
   output logic [7:0]           pend_vec,
   output logic [7:0]           ppr_out
);
   localparam int VEC_W    = $clog2(NUM_VEC);
   localparam int RSVD_VEC = RSVD_WORDS * WORD_W;

   initial begin : p_param_chk
      assert (VEC_W == PRIO_W) else $error("vector count must match priority width");
      assert (TPR_BUS_W >= PRIO_W) else $error("task priority bus too narrow");
      assert (STK_DEPTH >= (1 << CLS_W) - RSVD_VEC / (1 << (PRIO_W - CLS_W)))
         else $error("stack cannot hold every deliverable class");
   end

   logic [NUM_VEC-1:0] irr_q, isr_q;
   prio_t              tpr_q;
   logic               irr_found, isr_found;
   logic [VEC_W-1:0]   irr_hi, isr_hi;
   prio_t              top_vec, ppr;
   logic               eoi_eff;
   logic [NUM_VEC-1:0] set_mask, acc_mask, eoi_mask;

   if (TPR_BUS_W > PRIO_W) begin : g_tpr_hi
      logic unused_tpr_hi;
      assign unused_tpr_hi = ^tpr_wdata[TPR_BUS_W-1:PRIO_W];
   end

   vpa_hi_find #(
      .NUM_BITS(NUM_VEC), .WORD_W(WORD_W),
      .FIRST_WORD(RSVD_WORDS), .TWO_LEVEL(TWO_LEVEL_FIND)
   ) u_irr_find (.bits(irr_q), .found(irr_found), .idx(irr_hi));

   vpa_hi_find #(
      .NUM_BITS(NUM_VEC), .WORD_W(WORD_W),
      .FIRST_WORD(RSVD_WORDS), .TWO_LEVEL(TWO_LEVEL_FIND)
   ) u_isr_find (.bits(isr_q), .found(isr_found), .idx(isr_hi));

   assign eoi_eff  = eoi && isr_found;
   assign set_mask = set_valid ? (NUM_VEC'(1) << set_vec) : '0;
   assign acc_mask = acc_valid ? (NUM_VEC'(1) << acc_vec) : '0;
   assign eoi_mask = eoi_eff   ? (NUM_VEC'(1) << isr_hi)  : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tpr_q <= '0;
      end else begin
         irr_q <= (irr_q & ~acc_mask) | set_mask;
         isr_q <= (isr_q & ~eoi_mask) | acc_mask;
         if (tpr_we) tpr_q <= tpr_wdata[PRIO_W-1:0];
      end
   end

   vpa_nest_stack #(.DEPTH(STK_DEPTH)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push(acc_valid), .pop(eoi_eff),
      .push_vec(acc_vec), .top_vec(top_vec)
   );

   vpa_prio_calc u_prio (.tpr(tpr_q), .top_vec(top_vec), .ppr(ppr));

   assign pend_valid = irr_found && (prio_class(irr_hi) > prio_class(ppr));
   assign pend_vec   = pend_valid ? irr_hi : '0;
   assign ppr_out    = ppr;

   // R3: reserved vectors are never offered
   a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (int'(pend_vec) >= RSVD_VEC));

   // R4: processor priority never sits below the task priority
   a_r4_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
      ppr_out >= tpr_q);

   // R5: an accepted vector leaves the request set and enters service
   a_r5_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(set_valid && set_vec == acc_vec) && !isr_q[acc_vec])
      |=> (!irr_q[$past(acc_vec)] && isr_q[$past(acc_vec)]));

   // R6: end-of-interrupt with nothing in service leaves service state alone
   a_r6_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !isr_found && !acc_valid) |=> $stable(isr_q));

   // R7: only the low byte of the write is kept
   a_r7_tpr_byte: assert property (@(posedge clk) disable iff (!rst_n)
      tpr_we |=> (tpr_q == $past(tpr_wdata[PRIO_W-1:0])));

   // R8: a set coinciding with an accept is not lost
   a_r8_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (set_valid && acc_valid) |=> irr_q[$past(set_vec)]);

   // R10: no stray vector while nothing is offered
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_valid |-> (pend_vec == '0));
endmodule

// File: tb/vpa_arbiter_tb.sv
module vpa_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N_STEPS    = 19;

   typedef struct packed {
      logic [7:0]  req;
      logic        sv;
      logic [7:0]  svec;
      logic        av;
      logic [7:0]  avec;
      logic        eo;
      logic        tw;
      logic [31:0] tdat;
      logic        ev;
      logic [7:0]  evec;
      logic [7:0]  eppr;
   } step_t;

   // columns: req, set, setvec, acc, accvec, eoi, tprwe, tprdata, exp valid, exp vec, exp ppr
   localparam step_t TBL [N_STEPS] = '{
      '{8'd2, 1'b1, 8'h45, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 8'h45, 8'h00}, // R2 plain request
      '{8'd3, 1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 8'h45, 8'h00}, // R3 reserved underneath
      '{8'd5, 1'b0, 8'h00, 1'b1, 8'h45, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h40}, // R5 accept
      '{8'd2, 1'b1, 8'h43, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h40}, // R2 equal class blocked
      '{8'd2, 1'b1, 8'h52, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 8'h52, 8'h40}, // R2 higher class
      '{8'd8, 1'b1, 8'h60, 1'b1, 8'h52, 1'b0, 1'b0, 32'h0, 1'b1, 8'h60, 8'h50}, // R8 set+accept
      '{8'd7, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 32'h7A, 1'b0, 8'h00, 8'h7A}, // R7 tpr above
      '{8'd7, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0000_0130, 1'b1, 8'h60, 8'h50}, // R7 wide data
      '{8'd6, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, 1'b1, 8'h60, 8'h40}, // R6 eoi
      '{8'd5, 1'b0, 8'h00, 1'b1, 8'h60, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h60}, // R5 accept again
      '{8'd2, 1'b1, 8'h70, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 8'h70, 8'h60}, // R2
      '{8'd9, 1'b0, 8'h00, 1'b1, 8'h70, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00, 8'h70}, // R9 eoi+accept
      '{8'd6, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00, 8'h40}, // R6
      '{8'd4, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, 1'b1, 8'h43, 8'h30}, // R4 empty stack
      '{8'd6, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 32'h0, 1'b1, 8'h43, 8'h30}, // R6 eoi when idle
      '{8'd7, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 32'h0, 1'b1, 8'h43, 8'h00}, // R7 tpr zero
      '{8'd2, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 8'hFF, 8'h00}, // R2 top vector
      '{8'd8, 1'b1, 8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'hF0}, // R8 same vector
      '{8'd4, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 32'hF5, 1'b0, 8'h00, 8'hF5}  // R4 tie goes to tpr
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_valid = 1'b0;
   logic [7:0]  set_vec = '0;
   logic        acc_valid = 1'b0;
   logic [7:0]  acc_vec = '0;
   logic        eoi = 1'b0;
   logic        tpr_we = 1'b0;
   logic [31:0] tpr_wdata = '0;
   logic        pend_valid;
   logic [7:0]  pend_vec;
   logic [7:0]  ppr_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vpa_arbiter u_dut (
      .clk(clk), .rst_n(rst_n),
      .set_valid(set_valid), .set_vec(set_vec),
      .acc_valid(acc_valid), .acc_vec(acc_vec),
      .eoi(eoi), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
      .pend_valid(pend_valid), .pend_vec(pend_vec), .ppr_out(ppr_out)
   );

   task automatic check(input string tag, input logic ev, input logic [7:0] evec,
                        input logic [7:0] eppr);
      checks++;
      if (pend_valid !== ev || pend_vec !== evec || ppr_out !== eppr) begin
         failures++;
         $display("FAIL %s: valid=%0b vec=%02h ppr=%02h expected valid=%0b vec=%02h ppr=%02h",
                  tag, pend_valid, pend_vec, ppr_out, ev, evec, eppr);
      end
   endtask

   task automatic apply(input logic sv, input logic [7:0] svec, input logic av,
                        input logic [7:0] avec, input logic eo, input logic tw,
                        input logic [31:0] tdat);
      @(negedge clk);
      set_valid = sv; set_vec = svec; acc_valid = av; acc_vec = avec;
      eoi = eo; tpr_we = tw; tpr_wdata = tdat;
      @(posedge clk);
      #1;
      set_valid = 1'b0; acc_valid = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      check("R1 reset state", 1'b0, 8'h00, 8'h00);

      for (int i = 0; i < N_STEPS; i++) begin
         apply(TBL[i].sv, TBL[i].svec, TBL[i].av, TBL[i].avec,
               TBL[i].eo, TBL[i].tw, TBL[i].tdat);
         check($sformatf("R%0d step %0d", TBL[i].req, i),
               TBL[i].ev, TBL[i].evec, TBL[i].eppr);
      end

      // R1: reset from a busy state drops requests, service and tpr
      do_reset();
      #1;
      check("R1 reset from busy", 1'b0, 8'h00, 8'h00);

      // R3: boundary of the reserved range
      apply(1'b1, 8'h1F, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0);
      check("R3 vector 1F", 1'b0, 8'h00, 8'h00);
      apply(1'b1, 8'h20, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0);
      check("R3 vector 20", 1'b1, 8'h20, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule